// File: doc/BRIEF.md
# Masked-Write GPIO Port

A 32-pin general-purpose I/O port controlled over a simple 32-bit register bus. The bus has an address, write data, a write strobe and read data. Each pin has an output-enable bit and an output-level bit, and each pin's external level is sampled into the clock domain. Software never rewrites the whole direction word. One register turns pins into outputs wherever a write carries a 1, and a second register turns pins back into inputs in the same way. The read side of the direction registers shows the current direction vector.

Output levels are written in two halves of 16 pins each. In every half write, the upper 16 data bits choose which pins take a new level, and the lower 16 bits hold those levels. Pins whose select bit is 0 keep their level. Software can therefore change any one pin without first reading the port. Incoming pin levels pass through a two-flop synchronizer before they can be read. The level bits are driven whether or not a pin is an output, so a level can be preset before the pin is enabled.

Top module: `mgp_port`

## Requirements
- R1: While reset is asserted and right after it, pin_oe is all 0 (every pin an input), pin_out is all 0 and bus_rdata is 0.
- R2: A write to offset 0x00 sets pin_oe[i] to 1 for every bit i that is 1 in the write data, from the next clock edge on. Pins whose data bit is 0 keep their direction.
- R3: A write to offset 0x04 sets pin_oe[i] to 0 for every bit i that is 1 in the write data, from the next clock edge on. Pins whose data bit is 0 keep their direction.
- R4: A write to offset 0x08 updates pin_out[i] (i = 0..15) to wdata[i] for every i where wdata[16+i] is 1. The other low pins are unchanged.
- R5: A write to offset 0x0C updates pin_out[16+i] (i = 0..15) to wdata[i] for every i where wdata[16+i] is 1. The other high pins are unchanged.
- R6: A level write to 0x08 or 0x0C whose upper 16 bits are all 0 changes no output level, whatever its lower bits hold.
- R7: A read at offset 0x00 or 0x04 returns pin_oe (1 = output) on bus_rdata one clock edge after the address is presented.
- R8: A read at offset 0x10 returns pin_in after two synchronizer stages plus the read register. A pin change made before edge 1 appears on bus_rdata after edge 3, and the old value is still shown after edge 2.
- R9: A read at 0x08 returns pin_out[15:0], and a read at 0x0C returns pin_out[31:16], in bus_rdata[15:0] with bus_rdata[31:16] zero.
- R10: Writes to 0x10 or to any unmapped offset change neither pin_oe nor pin_out. Reads at unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| pin_in | input | 32 | Asynchronous pin levels from the pads |
| pin_out | output | 32 | Output level per pin |
| pin_oe | output | 32 | Output enable per pin, 1 = drive |

## Verification
Direction and level writes act at the first clock edge after the strobe. The bench drives each write on a falling edge and checks pin_oe and pin_out at the next falling edge. Read data is registered, so every read is presented on a falling edge and sampled one falling edge later. Pin input changes take three edges to reach bus_rdata. The bench samples after the second edge and expects the old value, then after the third edge and expects the new one, which pins the synchronizer depth from both sides.

// File: rtl/mgp_pkg.sv
package mgp_pkg;
  localparam int unsigned OFS_SET_OUT = 32'h00;
  localparam int unsigned OFS_SET_IN  = 32'h04;
  localparam int unsigned OFS_LVL_LO  = 32'h08;
  localparam int unsigned OFS_LVL_HI  = 32'h0C;
  localparam int unsigned OFS_PIN_IN  = 32'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SET_OUT,
    SEL_SET_IN,
    SEL_LVL_LO,
    SEL_LVL_HI,
    SEL_PIN_IN
  } reg_sel_e;
endpackage

// File: rtl/mgp_dir_reg.sv
module mgp_dir_reg #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                set_we,
  input  logic                clr_we,
  input  logic [NUM_PINS-1:0] wbits,
  output logic [NUM_PINS-1:0] dir_q
);
  always_ff @(posedge clk) begin
    if (rst)
      dir_q <= '0;
    else if (set_we)
      dir_q <= dir_q | wbits;
    else if (clr_we)
      dir_q <= dir_q & ~wbits;
  end

  // R2
  dir_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((dir_q & $past(wbits)) == $past(wbits)));
  // R3
  dir_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !set_we) |=> ((dir_q & $past(wbits)) == '0));
  // R10
  dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!set_we && !clr_we) |=> $stable(dir_q));
endmodule

// File: rtl/mgp_out_half.sv
module mgp_out_half #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [HALF_W-1:0] mask,
  input  logic [HALF_W-1:0] val,
  output logic [HALF_W-1:0] lvl_q
);
  always_ff @(posedge clk) begin
    if (rst)
      lvl_q <= '0;
    else if (we)
      lvl_q <= (lvl_q & ~mask) | (val & mask);
  end

  // R4
  lvl_upd_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (((lvl_q ^ $past(val)) & $past(mask)) == '0));
  // R6
  lvl_nomask_chk: assert property (@(posedge clk) disable iff (rst)
    (we && mask == '0) |=> $stable(lvl_q));
endmodule

// File: rtl/mgp_in_sync.sv
module mgp_in_sync #(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_async,
  output logic [NUM_PINS-1:0] pin_sync
);
  logic [NUM_PINS-1:0] stage_q [SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= pin_async;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign pin_sync = stage_q[SYNC_STAGES-1];

  if (SYNC_STAGES == 2) begin : g_chk
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
      if (rst) since_rst <= '0;
      else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end
    // R8
    sync_lat_chk: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 2'd2) |-> (pin_sync == $past(pin_async, 2)));
  end
endmodule

// File: rtl/mgp_port.sv
module mgp_port
  import mgp_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  localparam int HALF_W = NUM_PINS / 2;
  localparam int NUM_HALVES = 2;

  reg_sel_e sel;
  always_comb begin
    unique case (32'(bus_addr))
      OFS_SET_OUT: sel = SEL_SET_OUT;
      OFS_SET_IN:  sel = SEL_SET_IN;
      OFS_LVL_LO:  sel = SEL_LVL_LO;
      OFS_LVL_HI:  sel = SEL_LVL_HI;
      OFS_PIN_IN:  sel = SEL_PIN_IN;
      default:     sel = SEL_NONE;
    endcase
  end

  mgp_dir_reg #(.NUM_PINS(NUM_PINS)) u_dir (
    .clk    (clk),
    .rst    (rst),
    .set_we (bus_we && sel == SEL_SET_OUT),
    .clr_we (bus_we && sel == SEL_SET_IN),
    .wbits  (bus_wdata[NUM_PINS-1:0]),
    .dir_q  (pin_oe)
  );

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    localparam reg_sel_e MY_SEL = (h == 0) ? SEL_LVL_LO : SEL_LVL_HI;
    mgp_out_half #(.HALF_W(HALF_W)) u_half (
      .clk   (clk),
      .rst   (rst),
      .we    (bus_we && sel == MY_SEL),
      .mask  (bus_wdata[2*HALF_W-1:HALF_W]),
      .val   (bus_wdata[HALF_W-1:0]),
      .lvl_q (pin_out[h*HALF_W +: HALF_W])
    );
  end

  logic [NUM_PINS-1:0] pin_sync;
  mgp_in_sync #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .pin_async (pin_in),
    .pin_sync  (pin_sync)
  );

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    unique case (sel)
      SEL_SET_OUT, SEL_SET_IN: rd_next = DATA_W'(pin_oe);
      SEL_LVL_LO: rd_next = DATA_W'(pin_out[HALF_W-1:0]);
      SEL_LVL_HI: rd_next = DATA_W'(pin_out[NUM_PINS-1:HALF_W]);
      SEL_PIN_IN: rd_next = DATA_W'(pin_sync);
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  // R10
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_NONE) |=> (bus_rdata == '0));
  // R7
  dir_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_we && (sel == SEL_SET_OUT || sel == SEL_SET_IN)) |=> (bus_rdata == DATA_W'(pin_oe)));
  // R9
  lvl_rd_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_LVL_LO || sel == SEL_LVL_HI) |=> (bus_rdata[DATA_W-1:HALF_W] == '0));
endmodule

// File: tb/mgp_port_tb.sv
module mgp_port_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_oe;
  logic [31:0] exp_out;

  always #2 clk = ~clk;

  mgp_port u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'hFC; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic t_reset();
    rst = 1'b1; bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = '0; pin_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", pin_oe, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 oe", pin_oe, 32'h0);
    chk("R1 out", pin_out, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    pin_in = '0;
  endtask

  task automatic t_dir();
    logic [31:0] r;
    wr(8'h00, 32'h0000_00F0); exp_oe = 32'h0000_00F0;
    chk("R2 set", pin_oe, exp_oe);
    wr(8'h00, 32'h0F00_0000); exp_oe |= 32'h0F00_0000;
    chk("R2 keep zeros", pin_oe, exp_oe);
    wr(8'h04, 32'h0100_0030); exp_oe &= ~32'h0100_0030;
    chk("R3 clear", pin_oe, exp_oe);
    rd(8'h00, r); chk("R7 read 0x00", r, exp_oe);
    rd(8'h04, r); chk("R7 read 0x04", r, exp_oe);
  endtask

  task automatic t_levels();
    logic [31:0] r;
    wr(8'h08, 32'hFFFF_A5A5); exp_out[15:0] = 16'hA5A5;
    chk("R4 full low", pin_out, exp_out);
    wr(8'h08, 32'h000F_0000); exp_out[3:0] = 4'h0;
    chk("R4 masked low", pin_out, exp_out);
    wr(8'h0C, 32'h8001_FFFF); exp_out[31] = 1'b1; exp_out[16] = 1'b1;
    chk("R5 masked high", pin_out, exp_out);
    wr(8'h08, 32'h0000_1234);
    chk("R6 zero mask low", pin_out, exp_out);
    wr(8'h0C, 32'h0000_FFFF);
    chk("R6 zero mask high", pin_out, exp_out);
    rd(8'h08, r); chk("R9 read low", r, {16'h0, exp_out[15:0]});
    rd(8'h0C, r); chk("R9 read high", r, {16'h0, exp_out[31:16]});
  endtask

  task automatic t_input(input logic [31:0] v);
    logic [31:0] old;
    rd(8'h10, old);
    pin_in = v;
    @(negedge clk);
    @(negedge clk);
    chk("R8 old after 2 edges", bus_rdata, old);
    @(negedge clk);
    chk("R8 new after 3 edges", bus_rdata, v);
  endtask

  task automatic t_misc();
    logic [31:0] r;
    wr(8'h10, 32'hFFFF_FFFF);
    chk("R10 write 0x10 oe", pin_oe, exp_oe);
    chk("R10 write 0x10 out", pin_out, exp_out);
    wr(8'h20, 32'hFFFF_FFFF);
    chk("R10 unmapped write oe", pin_oe, exp_oe);
    chk("R10 unmapped write out", pin_out, exp_out);
    rd(8'h24, r); chk("R10 unmapped read", r, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    exp_oe = '0; exp_out = '0;
    t_reset();
    t_dir();
    t_levels();
    t_input(32'hDEAD_BEEF);
    t_input(32'h1234_5678);
    t_misc();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule